// File: doc/BRIEF.md
# Coin-Credit Snack Vending Controller

This block is the clocked decision core of a two-product snack machine. A coin path outside the block delivers each inserted coin as a value with a one-cycle valid strobe. The block adds that value to an 8-bit credit register. Two products are on offer, each at its own fixed price. Three separate buttons request candy and two request chips. When the request is present and the credit covers the price, the block issues a single-cycle vend pulse for that product.

A three-state sequencer controls the flow. It idles in a ready state until a coin arrives. It then collects credit and watches the buttons. A granted purchase takes it through a one-cycle vending state, after which it returns to ready. When it leaves vending, the price of the vended product is taken off the credit and any remainder is kept for the next purchase. The present credit and the state code are output for a display or a supervising controller.

Top module: `snack_vend_ctrl`

## Requirements
- R1: An active-high reset clears the credit to 0 and the state to ready without waiting for a clock edge, and both vend outputs are low while reset is held.
- R2: The state output encodes ready as 0, collecting as 1 and vending as 2. In ready, any valid coin, including one of value 0, moves the state to collecting at the next edge. Product buttons pressed in ready are ignored.
- R3: On each rising edge with the coin strobe high, the coin value is added to the credit. The sum saturates at 255 and never wraps.
- R4: The candy request is the OR of the three candy button bits, and the chips request is the OR of the two chip button bits, so any single bit is enough to make a request.
- R5: In collecting, a candy request with credit of 60 or more moves the state to vending with candy selected. Credit of 59 is not enough.
- R6: In collecting, a chips request with credit of 50 or more moves the state to vending with chips selected.
- R7: When both requests are present and both are affordable in the same cycle, candy is vended and chips is not.
- R8: The vending state lasts exactly one cycle. The selected vend output is high during that cycle only, and the next state is ready.
- R9: On leaving vending, the credit becomes the old credit minus the selected product's price (60 for candy, 50 for chips), plus a coin strobed in that cycle, saturating at 255.
- R10: Buttons pressed during the vending cycle have no effect on the vend outputs, the next state or the credit.
- R11: In collecting, a request whose price exceeds the credit leaves the state in collecting, with no vend pulse and the credit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| coin_valid | input | 1 | Strobe marking a coin value for this cycle |
| coin_value | input | 8 | Value of the coin being inserted |
| candy_btn | input | 3 | Candy request buttons, one bit per button |
| chips_btn | input | 2 | Chips request buttons, one bit per button |
| vend_candy | output | 1 | One-cycle candy dispense pulse |
| vend_chips | output | 1 | One-cycle chips dispense pulse |
| credit | output | 8 | Present accumulated credit |
| state | output | 2 | Sequencer state code (0 ready, 1 collecting, 2 vending) |

## Verification
The bench targets the price edges at 59 and 60 for candy and at exactly 50 for chips. A comparison off by one would vend early or refuse a fully paid purchase. It drives a simultaneous affordable request for both products, where a wrong priority gives chips or two pulses. It pushes coins past 255, where a wrapping adder would leave a small credit, and presses buttons in the ready and vending states, where a leaky sequencer would vend again or take off a second price. A reset raised between clock edges must clear the outputs at once, which shows a reset that has wrongly been made synchronous.

// File: rtl/svc_pkg.sv
package svc_pkg;

  typedef enum logic [1:0] {
    ST_READY   = 2'd0,
    ST_COLLECT = 2'd1,
    ST_VEND    = 2'd2
  } svc_state_e;

  // selection code held through the vending cycle: {candy, chips}
  localparam int unsigned PICK_W = 2;

endpackage

// File: rtl/svc_req_merge.sv
module svc_req_merge #(
  parameter int unsigned NBTN = 2
) (
  input  logic [NBTN-1:0] btn,
  output logic            req
);
  assign req = |btn;
endmodule

// File: rtl/svc_credit_reg.sv
module svc_credit_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         coin_valid,
  input  logic [W-1:0] coin,
  input  logic         sub_en,
  input  logic [W-1:0] price,
  output logic [W-1:0] credit
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  function automatic logic [W-1:0] sat_add(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[W] ? TOP : s[W-1:0];
  endfunction

  logic [W-1:0] base_w;
  logic [W-1:0] addend_w;
  logic [W-1:0] credit_nx;

  assign base_w    = sub_en ? (credit - price) : credit;
  assign addend_w  = coin_valid ? coin : '0;
  assign credit_nx = sat_add(base_w, addend_w);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) credit <= '0;
    else     credit <= credit_nx;
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (coin_valid && !sub_en) |=> (credit >= $past(credit)));

  p_deduct_price_r9: assert property (@(posedge clk) disable iff (rst)
    (sub_en && !coin_valid) |=> (credit == $past(credit) - $past(price)));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!sub_en && !coin_valid) |=> $stable(credit));

endmodule

// File: rtl/svc_seq_fsm.sv
module svc_seq_fsm
  import svc_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned CANDY_PRICE = 60,
  parameter int unsigned CHIPS_PRICE = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              coin_valid,
  input  logic              candy_req,
  input  logic              chips_req,
  input  logic [W-1:0]      credit,
  output svc_state_e        state_q,
  output logic [PICK_W-1:0] pick_q
);
  localparam logic [W-1:0] CANDY_P = W'(CANDY_PRICE);
  localparam logic [W-1:0] CHIPS_P = W'(CHIPS_PRICE);

  function automatic logic covers(input logic [W-1:0] cr, input logic [W-1:0] p);
    return cr >= p;
  endfunction

  logic grant_candy;
  logic grant_chips;
  svc_state_e        state_nx;
  logic [PICK_W-1:0] pick_nx;

  assign grant_candy = (state_q == ST_COLLECT) && candy_req && covers(credit, CANDY_P);
  assign grant_chips = (state_q == ST_COLLECT) && chips_req && covers(credit, CHIPS_P)
                       && !grant_candy;

  always_comb begin
    state_nx = state_q;
    pick_nx  = '0;
    case (state_q)
      ST_READY:   if (coin_valid) state_nx = ST_COLLECT;
      ST_COLLECT: begin
        if (grant_candy) begin
          state_nx = ST_VEND;
          pick_nx  = 2'b10;
        end else if (grant_chips) begin
          state_nx = ST_VEND;
          pick_nx  = 2'b01;
        end
      end
      ST_VEND:    state_nx = ST_READY;
      default:    state_nx = ST_READY;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state_q <= ST_READY;
      pick_q  <= '0;
    end else begin
      state_q <= state_nx;
      pick_q  <= pick_nx;
    end
  end

  p_vend_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_VEND) |=> (state_q == ST_READY));

  p_ready_needs_coin_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READY && !coin_valid) |=> (state_q == ST_READY));

  p_vend_has_pick_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_VEND) |-> ($countones(pick_q) == 1));

endmodule

// File: rtl/snack_vend_ctrl.sv
module snack_vend_ctrl
  import svc_pkg::*;
#(
  parameter int unsigned CREDIT_W    = 8,
  parameter int unsigned CANDY_BTNS  = 3,
  parameter int unsigned CHIPS_BTNS  = 2,
  parameter int unsigned CANDY_PRICE = 60,
  parameter int unsigned CHIPS_PRICE = 50
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  coin_valid,
  input  logic [CREDIT_W-1:0]   coin_value,
  input  logic [CANDY_BTNS-1:0] candy_btn,
  input  logic [CHIPS_BTNS-1:0] chips_btn,
  output logic                  vend_candy,
  output logic                  vend_chips,
  output logic [CREDIT_W-1:0]   credit,
  output logic [1:0]            state
);
  localparam logic [CREDIT_W-1:0] CANDY_P = CREDIT_W'(CANDY_PRICE);
  localparam logic [CREDIT_W-1:0] CHIPS_P = CREDIT_W'(CHIPS_PRICE);

  logic candy_req_w;
  logic chips_req_w;
  logic vending_w;
  logic [CREDIT_W-1:0] price_w;
  svc_state_e          state_w;
  logic [PICK_W-1:0]   pick_w;

  svc_req_merge #(.NBTN(CANDY_BTNS)) u_candy_req (.btn(candy_btn), .req(candy_req_w));
  svc_req_merge #(.NBTN(CHIPS_BTNS)) u_chips_req (.btn(chips_btn), .req(chips_req_w));

  svc_seq_fsm #(
    .W(CREDIT_W), .CANDY_PRICE(CANDY_PRICE), .CHIPS_PRICE(CHIPS_PRICE)
  ) u_fsm (
    .clk(clk), .rst(rst), .coin_valid(coin_valid),
    .candy_req(candy_req_w), .chips_req(chips_req_w),
    .credit(credit), .state_q(state_w), .pick_q(pick_w)
  );

  assign vending_w = (state_w == ST_VEND);
  assign price_w   = pick_w[1] ? CANDY_P : CHIPS_P;

  svc_credit_reg #(.W(CREDIT_W)) u_credit (
    .clk(clk), .rst(rst), .coin_valid(coin_valid), .coin(coin_value),
    .sub_en(vending_w), .price(price_w), .credit(credit)
  );

  assign vend_candy = vending_w & pick_w[1];
  assign vend_chips = vending_w & pick_w[0];
  assign state      = state_w;

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({vend_candy, vend_chips}));

  p_candy_paid_r5: assert property (@(posedge clk) disable iff (rst)
    vend_candy |-> (credit >= CANDY_P));

  p_chips_paid_r6: assert property (@(posedge clk) disable iff (rst)
    vend_chips |-> (credit >= CHIPS_P));

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |-> (!vend_candy && !vend_chips && credit == '0));

endmodule

// File: tb/test_snack_vend_ctrl.sv
`timescale 1ns/1ps
module test_snack_vend_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       coin_valid = 1'b0;
  logic [7:0] coin_value = '0;
  logic [2:0] candy_btn = '0;
  logic [1:0] chips_btn = '0;
  logic       vend_candy, vend_chips;
  logic [7:0] credit;
  logic [1:0] state;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  snack_vend_ctrl i_snack_vend_ctrl (
    .clk(clk), .rst(rst), .coin_valid(coin_valid), .coin_value(coin_value),
    .candy_btn(candy_btn), .chips_btn(chips_btn),
    .vend_candy(vend_candy), .vend_chips(vend_chips),
    .credit(credit), .state(state)
  );

  // vector: {cv, coin[8], candy[3], chips[2], exp_state[2], exp_credit[8], exp_vc, exp_vh}
  localparam int NV = 18;
  localparam logic [25:0] VECS [NV] = '{
    {1'b1, 8'd20,  3'b000, 2'b00, 2'd1, 8'd20,  1'b0, 1'b0}, // R2 R3 coin in ready
    {1'b0, 8'd0,   3'b001, 2'b00, 2'd1, 8'd20,  1'b0, 1'b0}, // R11 candy too dear
    {1'b1, 8'd30,  3'b000, 2'b00, 2'd1, 8'd50,  1'b0, 1'b0}, // R3 accumulate
    {1'b0, 8'd0,   3'b100, 2'b00, 2'd1, 8'd50,  1'b0, 1'b0}, // R11 candy at 50
    {1'b0, 8'd0,   3'b000, 2'b01, 2'd2, 8'd50,  1'b0, 1'b1}, // R6 chips at exactly 50
    {1'b0, 8'd0,   3'b000, 2'b00, 2'd0, 8'd0,   1'b0, 1'b0}, // R8 R9 back to ready
    {1'b0, 8'd0,   3'b010, 2'b00, 2'd0, 8'd0,   1'b0, 1'b0}, // R2 button in ready
    {1'b1, 8'd100, 3'b000, 2'b00, 2'd1, 8'd100, 1'b0, 1'b0}, // R3
    {1'b0, 8'd0,   3'b010, 2'b10, 2'd2, 8'd100, 1'b1, 1'b0}, // R7 R4 both affordable
    {1'b0, 8'd0,   3'b000, 2'b10, 2'd0, 8'd40,  1'b0, 1'b0}, // R10 R9 chips during vend
    {1'b0, 8'd0,   3'b000, 2'b10, 2'd0, 8'd40,  1'b0, 1'b0}, // R2 remainder, ready ignores
    {1'b1, 8'd10,  3'b000, 2'b01, 2'd1, 8'd50,  1'b0, 1'b0}, // R2 coin wins in ready
    {1'b0, 8'd0,   3'b000, 2'b10, 2'd2, 8'd50,  1'b0, 1'b1}, // R4 R6 second chips button
    {1'b1, 8'd5,   3'b000, 2'b00, 2'd0, 8'd5,   1'b0, 1'b0}, // R9 coin in vend cycle
    {1'b1, 8'd200, 3'b000, 2'b00, 2'd1, 8'd205, 1'b0, 1'b0}, // R3
    {1'b1, 8'd100, 3'b000, 2'b00, 2'd1, 8'd255, 1'b0, 1'b0}, // R3 saturation
    {1'b0, 8'd0,   3'b001, 2'b00, 2'd2, 8'd255, 1'b1, 1'b0}, // R5 R4
    {1'b0, 8'd0,   3'b000, 2'b00, 2'd0, 8'd195, 1'b0, 1'b0}  // R8 R9
  };

  function automatic string vec_req(input int i);
    case (i)
      0, 6, 10, 11: return "R2";
      1, 3:         return "R11";
      2, 7, 14, 15: return "R3";
      4, 12:        return "R6";
      5, 17:        return "R8";
      8:            return "R7";
      9:            return "R10";
      13:           return "R9";
      16:           return "R5";
      default:      return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [1:0] es, input logic [7:0] ec,
                       input logic evc, input logic evh);
    total++;
    if (state !== es || credit !== ec || vend_candy !== evc || vend_chips !== evh) begin
      bad++;
      $display("FAIL %s: got state=%0d credit=%0d vc=%0b vh=%0b exp state=%0d credit=%0d vc=%0b vh=%0b",
               req, state, credit, vend_candy, vend_chips, es, ec, evc, evh);
    end
  endtask

  task automatic step(input logic cv, input logic [7:0] cn,
                      input logic [2:0] cb, input logic [1:0] hb);
    @(negedge clk);
    coin_valid = cv; coin_value = cn; candy_btn = cb; chips_btn = hb;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #5;
    check("R1", 2'd0, 8'd0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i][25], VECS[i][24:17], VECS[i][16:14], VECS[i][13:12]);
      check(vec_req(i), VECS[i][11:10], VECS[i][9:2], VECS[i][1], VECS[i][0]);
    end

    // R1: reset raised between edges clears at once
    step(1'b1, 8'd30, 3'b000, 2'b00);
    check("R3", 2'd1, 8'd225, 1'b0, 1'b0);
    @(negedge clk);
    coin_valid = 1'b0;
    rst = 1'b1;
    #1;
    check("R1", 2'd0, 8'd0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // R5 boundary: 59 refused, 60 accepted
    step(1'b1, 8'd59, 3'b000, 2'b00);
    check("R3", 2'd1, 8'd59, 1'b0, 1'b0);
    step(1'b0, 8'd0, 3'b100, 2'b00);
    check("R5", 2'd1, 8'd59, 1'b0, 1'b0);
    step(1'b1, 8'd1, 3'b000, 2'b00);
    check("R3", 2'd1, 8'd60, 1'b0, 1'b0);
    step(1'b0, 8'd0, 3'b010, 2'b00);
    check("R5", 2'd2, 8'd60, 1'b1, 1'b0);
    step(1'b0, 8'd0, 3'b111, 2'b11);
    check("R10", 2'd0, 8'd0, 1'b0, 1'b0);

    // R2: zero-value coin still leaves ready
    step(1'b1, 8'd0, 3'b000, 2'b00);
    check("R2", 2'd1, 8'd0, 1'b0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule